// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block controls one bank of general-purpose pins (32 by default) from a small 32-bit register bus. Software samples the pin levels, drives output data and output-enable through separate write-one-to-set and write-one-to-clear ports (so a single bit changes without read-modify-write), and arms each pin for a rising edge, a falling edge or both. Detected edges land in a pending register that software clears by writing ones, and a single interrupt line tells the processor that some pending bit is set.

Pin inputs cross into the clock domain through a two-flop synchroniser. The synchronised level feeds both the level register and an edge detector, which compares it with its value one cycle earlier. Pin n maps to bit n of every register.

A two-state bus sequencer handles each access. In `ST_IDLE` a request is captured and the sequencer takes the transition *accept* to `ST_ACK`. In `ST_ACK` the acknowledge is high for exactly one cycle: a write takes effect at the end of that cycle and read data is valid during it. The transition *complete* always returns to `ST_IDLE`, so a request still held during `ST_ACK` is ignored.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, output data, output enable, both edge enable masks and the pending register are zero, and `irq` and `bus_ack` are low.
- R2: A request seen in the idle state is acknowledged exactly one cycle later, for one cycle. A request held during the acknowledge cycle is ignored. `bus_rdata` is zero except during the acknowledge of a read.
- R3: A read of offset 0x00 returns the synchronised pin levels. A pin change made before clock edge k is readable in an acknowledge cycle that starts at edge k+1.
- R4: Writing a mask to 0x14 sets output-data bits where the mask is one, and writing to 0x18 clears them. Zero bits leave the outputs unchanged.
- R5: Writing a mask to 0x1C sets output-enable bits and writing to 0x20 clears them. Zero bits leave them unchanged.
- R6: Offset 0x28 is a read/write rising-edge enable mask. A rising edge on a pin with its bit set sets pending bit n.
- R7: Offset 0x2C is a read/write falling-edge enable mask. With both masks set, either edge sets pending. An edge on a pin whose enable for that direction is clear sets nothing.
- R8: A read of 0x0C returns the pending bits. Writing ones to 0x0C clears those bits, and zero bits are left unchanged.
- R9: If an enabled edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R10: `irq` is high whenever any pending bit is set and stays high until every pending bit is cleared.
- R11: Reads of the set/clear offsets (0x14, 0x18, 0x1C, 0x20) and of unmapped offsets return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data / mask |
| bus_rdata | output | DATA_W (32) | Read data, valid while acknowledging a read |
| bus_ack | output | 1 | One-cycle acknowledge |
| gpio_in | input | NPINS (32) | Pin levels from the pads, asynchronous |
| gpio_out | output | NPINS (32) | Output data to the pads |
| gpio_oe | output | NPINS (32) | Output driver enables |
| irq | output | 1 | Combined interrupt, high while any bit is pending |

## Verification
The two functions that can coincide are edge capture into the pending register and a software write that clears the same bit. The bench raises an armed pin and launches the clearing write 0, 1, 2 and 3 cycles later. The 1-cycle offset makes the write's acknowledge cycle the same cycle in which the edge detector fires. Reading the pending register afterwards must show the bit still set for offsets 0 and 1, since set wins or the clear arrives first, and cleared for offsets 2 and 3.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Register offsets; software depends on these values.
    localparam int unsigned OFS_LEVEL    = 32'h00;
    localparam int unsigned OFS_PEND     = 32'h0C;
    localparam int unsigned OFS_DOUT_SET = 32'h14;
    localparam int unsigned OFS_DOUT_CLR = 32'h18;
    localparam int unsigned OFS_DRV_SET  = 32'h1C;
    localparam int unsigned OFS_DRV_CLR  = 32'h20;
    localparam int unsigned OFS_RISE_EN  = 32'h28;
    localparam int unsigned OFS_FALL_EN  = 32'h2C;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);
    bus_state_e state_q, state_d;

    // Next-state selection: accept (IDLE->ACK), complete (ACK->IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture of the accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_we    <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else if (state_q == ST_IDLE && req) begin
            acc_we    <= we;
            acc_addr  <= addr;
            acc_wdata <= wdata;
        end
    end

    // Outputs.
    always_comb begin
        ack = (state_q == ST_ACK);
    end

    // R2: an accepted request is acknowledged on the next cycle.
    assert_req_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> ack);
    // R2: the acknowledge lasts a single cycle.
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] pending,
    output logic             irq
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] edge_hit;

    always_comb begin
        edge_hit = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lvl;
            pend_q <= (pend_q & ~clr_mask) | edge_hit;   // set wins
        end
    end

    assign pending = pend_q;
    assign irq     = |pend_q;

    // R9: an edge and a clear on the same bit leave it set.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & clr_mask) != '0) |=>
        ((pend_q & $past(edge_hit & clr_mask)) == $past(edge_hit & clr_mask)));
    // R8: cleared bits without a coincident edge are zero afterwards.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pend_q & $past(clr_mask & ~edge_hit)) == '0));
    // R7: no pending bit appears without a detected enabled edge.
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
    // R10: interrupt drops only when nothing remains pending.
    assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0 && edge_hit == '0) |=> !irq);
    assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~clr_mask) != '0) |=> irq);

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic [NPINS-1:0]  gpio_in,
    output logic [NPINS-1:0]  gpio_out,
    output logic [NPINS-1:0]  gpio_oe,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NPINS;

    logic              acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [NPINS-1:0]  wmask;
    logic [NPINS-1:0]  lvl_sync;
    logic [NPINS-1:0]  pend;
    logic [NPINS-1:0]  out_q, oe_q, rise_q, fall_q;
    logic              wr;
    logic              wr_dout_set, wr_dout_clr, wr_drv_set, wr_drv_clr;
    logic              wr_rise, wr_fall, wr_pend;
    logic [NPINS-1:0]  clr_mask;

    gpio_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .ack(bus_ack), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(lvl_sync)
    );

    assign wmask       = acc_wdata[NPINS-1:0];
    assign wr          = bus_ack && acc_we;
    assign wr_dout_set = wr && (acc_addr == ADDR_W'(OFS_DOUT_SET));
    assign wr_dout_clr = wr && (acc_addr == ADDR_W'(OFS_DOUT_CLR));
    assign wr_drv_set  = wr && (acc_addr == ADDR_W'(OFS_DRV_SET));
    assign wr_drv_clr  = wr && (acc_addr == ADDR_W'(OFS_DRV_CLR));
    assign wr_rise     = wr && (acc_addr == ADDR_W'(OFS_RISE_EN));
    assign wr_fall     = wr && (acc_addr == ADDR_W'(OFS_FALL_EN));
    assign wr_pend     = wr && (acc_addr == ADDR_W'(OFS_PEND));
    assign clr_mask    = wr_pend ? wmask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            out_q <= (out_q | (wr_dout_set ? wmask : '0)) & ~(wr_dout_clr ? wmask : '0);
            oe_q  <= (oe_q  | (wr_drv_set  ? wmask : '0)) & ~(wr_drv_clr  ? wmask : '0);
            if (wr_rise) rise_q <= wmask;
            if (wr_fall) fall_q <= wmask;
        end
    end

    gpio_irq_ctrl #(.WIDTH(NPINS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .lvl(lvl_sync), .rise_en(rise_q), .fall_en(fall_q),
        .clr_mask(clr_mask), .pending(pend), .irq(irq)
    );

    // Read mux: only readable offsets return data, only during a read acknowledge.
    always_comb begin
        bus_rdata = '0;
        if (bus_ack && !acc_we) begin
            case (acc_addr)
                ADDR_W'(OFS_LEVEL):   bus_rdata = DATA_W'({{PAD_W{1'b0}}, lvl_sync});
                ADDR_W'(OFS_PEND):    bus_rdata = DATA_W'({{PAD_W{1'b0}}, pend});
                ADDR_W'(OFS_RISE_EN): bus_rdata = DATA_W'({{PAD_W{1'b0}}, rise_q});
                ADDR_W'(OFS_FALL_EN): bus_rdata = DATA_W'({{PAD_W{1'b0}}, fall_q});
                default:              bus_rdata = '0;
            endcase
        end
    end

    assign gpio_out = out_q;
    assign gpio_oe  = oe_q;

    // R4: output data moves only on its set/clear strobes.
    assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dout_set || wr_dout_clr) |=> $stable(gpio_out));
    // R5: output enable moves only on its set/clear strobes.
    assert_oe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_drv_set || wr_drv_clr) |=> $stable(gpio_oe));
    // R2: no read data outside an acknowledge.
    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
    import gpio_edge_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ack;
    logic [31:0] gpio_in, gpio_out, gpio_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int ack_seen = 0;

    logic [31:0] exp_q [$];
    bit          chk_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one scoreboard entry per acknowledge.
    always @(negedge clk) begin : monitor
        logic [31:0] e;
        bit          c;
        string       t;
        if (rst_n && bus_ack) begin
            ack_seen++;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected acknowledge actual 1 expected 0");
            end else begin
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check32(t, bus_rdata, e);
            end
        end
    end

    task automatic bus_op(input logic we, input logic [7:0] a, input logic [31:0] d,
                          input bit c, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_op(1'b1, a, d, 1'b0, '0, "write");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_op(1'b0, a, '0, 1'b1, e, t);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin : main
        int base;
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        gpio_in = '0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);

        // R1 reset state
        check32("R1 gpio_out reset", gpio_out, 32'h0);
        check32("R1 gpio_oe reset", gpio_oe, 32'h0);
        check32("R1 irq reset", {31'h0, irq}, 32'h0);
        check32("R1 ack reset", {31'h0, bus_ack}, 32'h0);
        rd(8'h28, 32'h0, "R1 rise mask reset");
        rd(8'h2C, 32'h0, "R1 fall mask reset");
        rd(8'h0C, 32'h0, "R1 pending reset");

        // R4 output data set/clear
        wr(8'h14, 32'h0000_00F0);
        check32("R4 set F0", gpio_out, 32'h0000_00F0);
        wr(8'h14, 32'h0F00_0001);
        check32("R4 set merges", gpio_out, 32'h0F00_00F1);
        wr(8'h18, 32'h0000_0030);
        check32("R4 clear 30", gpio_out, 32'h0F00_00C1);

        // R5 output enable set/clear
        wr(8'h1C, 32'hFFFF_0000);
        check32("R5 oe set", gpio_oe, 32'hFFFF_0000);
        wr(8'h20, 32'h00FF_0000);
        check32("R5 oe clear", gpio_oe, 32'hFF00_0000);
        check32("R5 dout untouched", gpio_out, 32'h0F00_00C1);

        // R3 level read, two-flop latency
        @(negedge clk);
        gpio_in = 32'hA5A5_1234;
        rd(8'h00, 32'hA5A5_1234, "R3 level after sync");

        // R11 write-only and unmapped offsets
        rd(8'h14, 32'h0, "R11 read dout set port");
        rd(8'h20, 32'h0, "R11 read oe clear port");
        rd(8'h04, 32'h0, "R11 read unmapped");
        wr(8'h40, 32'hFFFF_FFFF);
        check32("R11 unmapped write dout", gpio_out, 32'h0F00_00C1);
        check32("R11 unmapped write oe", gpio_oe, 32'hFF00_0000);
        rd(8'h28, 32'h0, "R11 unmapped write rise mask");

        // R2 held request acknowledged once, idle rdata zero
        base = ack_seen;
        @(negedge clk);
        exp_q.push_back('0); chk_q.push_back(1'b0); tag_q.push_back("held");
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0;
        @(negedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        wait_cycles(3);
        check32("R2 one ack for held request", ack_seen - base, 32'd1);
        check32("R2 rdata idle zero", bus_rdata, 32'h0);

        // R6 rising edges
        gpio_in = '0;
        wait_cycles(4);
        wr(8'h28, 32'h0000_0009);
        rd(8'h28, 32'h0000_0009, "R6 rise mask readback");
        gpio_in = 32'h0000_000B;
        wait_cycles(5);
        rd(8'h0C, 32'h0000_0009, "R6 pending from rises");
        check32("R10 irq with pending", {31'h0, irq}, 32'h1);
        gpio_in = 32'h0000_000A;
        wait_cycles(5);
        rd(8'h0C, 32'h0000_0009, "R7 fall without enable ignored");

        // R8 write-one-to-clear
        wr(8'h0C, 32'h0000_0001);
        rd(8'h0C, 32'h0000_0008, "R8 partial clear");
        check32("R10 irq held while bit left", {31'h0, irq}, 32'h1);
        wr(8'h0C, 32'h0000_0000);
        rd(8'h0C, 32'h0000_0008, "R8 zero write no effect");
        wr(8'h0C, 32'h0000_0008);
        rd(8'h0C, 32'h0000_0000, "R8 full clear");
        check32("R10 irq low after clear", {31'h0, irq}, 32'h0);

        // R7 falling and both edges
        wr(8'h28, 32'h0000_0029);
        wr(8'h2C, 32'h0000_0120);
        rd(8'h2C, 32'h0000_0120, "R7 fall mask readback");
        gpio_in = 32'h0000_010A;
        wait_cycles(5);
        rd(8'h0C, 32'h0, "R7 rise on fall-only pin ignored");
        gpio_in = 32'h0000_000A;
        wait_cycles(5);
        rd(8'h0C, 32'h0000_0100, "R7 falling edge");
        wr(8'h0C, 32'h0000_0100);
        gpio_in = 32'h0000_002A;
        wait_cycles(5);
        rd(8'h0C, 32'h0000_0020, "R7 both-edge pin rise");
        wr(8'h0C, 32'h0000_0020);
        gpio_in = 32'h0000_000A;
        wait_cycles(5);
        rd(8'h0C, 32'h0000_0020, "R7 both-edge pin fall");
        wr(8'h0C, 32'h0000_0020);
        check32("R10 irq low again", {31'h0, irq}, 32'h0);

        // R9 edge versus clear sweep on pin 3
        gpio_in = '0;
        wait_cycles(4);
        for (int d = 0; d < 4; d++) begin
            @(negedge clk);
            gpio_in[3] = 1'b1;
            repeat (d) @(negedge clk);
            exp_q.push_back('0); chk_q.push_back(1'b0); tag_q.push_back("clr");
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h8;
            @(negedge clk);
            bus_req = 1'b0; bus_we = 1'b0;
            wait_cycles(5);
            rd(8'h0C, (d <= 1) ? 32'h8 : 32'h0, $sformatf("R9 set-wins sweep d=%0d", d));
            gpio_in[3] = 1'b0;
            wait_cycles(4);
            wr(8'h0C, 32'h8);
        end
        check32("R10 irq low after sweep", {31'h0, irq}, 32'h0);

        wait_cycles(2);
        finish_run();
    end

endmodule